// File: doc/BRIEF.md
# Retriggerable Limiter Retry Sequencer

This block sits beside a latching current-limiter core and turns it into a self-retrying limiter. It watches the core for trip events. While retrying is allowed, each trip starts a fixed retry interval, and when the interval ends the block asks the core to switch back ON. As long as the overload keeps tripping the core, the cycle repeats. Once the overload clears, the core simply stays ON. This kind of limiter has no OFF command. The only way to keep a failed load switched off is to withdraw retry permission, and that needs a deliberate two-step command.

The block holds the commanded retry permission itself. At power-up it asks for ON and writes permission to the core. It also repairs corrupted core state on its own. If the core reads OFF without a recorded trip for a watchdog interval, the block asks for ON again. If the core's permission latch disagrees with the commanded value for a scrub interval, the block rewrites the latch. The retry interval is a parameter in clock cycles and must be longer than the core's trip-off time.

Top module: `relimit_seq`

## Requirements
- R1: During reset `on_req_o`, `en_wr_o`, `retry_wait_o` and `latched_off_o` are 0 and `retrig_en_o` is 1. After `rst_n` is released, `on_req_o` and `en_wr_o` are both 1 in the third cycle, counting two cycles of reset synchronisation.
- R2: A one-cycle `trip_i` pulse taken while retry is permitted raises `retry_wait_o`. `on_req_o` then pulses exactly RETRY_CYC+1 cycles after the cycle in which the trip was driven.
- R3: Repeated trips, each arriving a few cycles after the previous ON request (a persisting overload), are each retried with the same latency.
- R4: While `core_on_i` stays 1 and no trip arrives, `on_req_o` stays 0.
- R5: An arm pulse (`cmd_arm_i`) followed by a confirm pulse (`cmd_confirm_i`) 1 to ARM_WIN cycles later clears `retrig_en_o` in the cycle after the confirm. `en_wr_o` pulses in that same cycle. Every change of `retrig_en_o` is accompanied by an `en_wr_o` pulse.
- R6: A confirm arriving ARM_WIN+1 or more cycles after the arm, or with no arm before it, is ignored: `retrig_en_o` stays 1 and `en_wr_o` stays 0.
- R7: A trip taken while retry is withdrawn sets `latched_off_o` in the next cycle, and no ON request follows. A `cmd_enable_i` pulse sets `retrig_en_o` and pulses `en_wr_o` in the next cycle. It then raises `on_req_o` two cycles after it was driven.
- R8: Withdrawing retry permission while a retry interval is running cancels the pending ON request and leaves `latched_off_o` at 1.
- R9: If `core_on_i` drops with no trip, `on_req_o` pulses WDOG_CYC+1 cycles after the drop.
- R10: If `core_en_i` differs from `retrig_en_o` for SCRUB_CYC consecutive cycles, `en_wr_o` pulses SCRUB_CYC cycles after the mismatch began. A mismatch lasting SCRUB_CYC-1 cycles causes no write.
- R11: `on_req_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trip_i | input | 1 | One-cycle pulse: the core has tripped off on overload |
| core_on_i | input | 1 | Core switch state read back (1 = ON) |
| core_en_i | input | 1 | Core retry-permission latch read back |
| cmd_arm_i | input | 1 | Telecommand pulse: arm withdrawal of retry permission |
| cmd_confirm_i | input | 1 | Telecommand pulse: confirm withdrawal |
| cmd_enable_i | input | 1 | Telecommand pulse: grant retry permission |
| on_req_o | output | 1 | One-cycle request to switch the core ON |
| en_wr_o | output | 1 | One-cycle write of `retrig_en_o` into the core's permission latch |
| retrig_en_o | output | 1 | Commanded retry permission |
| retry_wait_o | output | 1 | A retry interval is running |
| latched_off_o | output | 1 | Core held off because retry permission is withdrawn |

## Verification
The assertions assume that `trip_i` and every command input are one-cycle pulses. They also assume that a trip is reported only while the core is ON or was just switched ON, and that `core_on_i` and `core_en_i` follow the block's requests within a cycle. The stimulus models the core the same way. It drops `core_on_i` together with each trip pulse and raises it again in the cycle where the ON request appears. It copies the permission value into `core_en_i` right after each write, except in the cases that deliberately corrupt it. Commands are never issued in the same cycle as one another.

// File: rtl/relimit_pkg.sv
package relimit_pkg;

  typedef enum logic [2:0] {
    SQ_BOOT   = 3'd0,
    SQ_ON     = 3'd1,
    SQ_WAIT   = 3'd2,
    SQ_OFFCHK = 3'd3,
    SQ_HOLD   = 3'd4
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/relimit_rst_sync.sv
module relimit_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n_o = stage2_q;
endmodule

// File: rtl/relimit_span_timer.sv
module relimit_span_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [CW-1:0] last_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expire_o = run_i && (cnt_q == last_i);

  always_comb begin
    cnt_en = clr_i | run_i;
    if (clr_i || expire_o) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i) |-> (cnt_q <= last_i)) else $error("timer past limit"); // R2
endmodule

// File: rtl/relimit_retry_fsm.sv
module relimit_retry_fsm
  import relimit_pkg::*;
#(
  parameter int RETRY_CYC = 40,
  parameter int WDOG_CYC  = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic core_on_i,
  input  logic en_i,
  output logic on_req_o,
  output logic wait_o,
  output logic hold_o
);
  localparam int unsigned CNT_MAX = max2(RETRY_CYC, WDOG_CYC);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] RETRY_LAST = CW'(RETRY_CYC - 1);
  localparam logic [CW-1:0] WDOG_LAST  = CW'(WDOG_CYC - 1);

  seq_state_e    state_q, state_d;
  logic          on_q, on_d;
  logic          tmr_clr, tmr_run, tmr_exp;
  logic [CW-1:0] tmr_last;

  relimit_span_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tmr_clr),
    .run_i    (tmr_run),
    .last_i   (tmr_last),
    .expire_o (tmr_exp)
  );

  always_comb begin
    state_d  = state_q;
    on_d     = 1'b0;
    tmr_clr  = 1'b1;
    tmr_run  = 1'b0;
    tmr_last = WDOG_LAST;
    unique case (state_q)
      SQ_BOOT: begin
        state_d = SQ_ON;
        on_d    = 1'b1;
      end
      SQ_ON: begin
        if (trip_i)          state_d = en_i ? SQ_WAIT : SQ_HOLD;
        else if (!core_on_i) state_d = SQ_OFFCHK;
      end
      SQ_OFFCHK: begin
        if (trip_i) begin
          state_d = en_i ? SQ_WAIT : SQ_HOLD;
        end else if (core_on_i) begin
          state_d = SQ_ON;
        end else begin
          tmr_clr = 1'b0;
          tmr_run = 1'b1;
          if (tmr_exp) begin
            state_d = SQ_ON;
            on_d    = 1'b1;
          end
        end
      end
      SQ_WAIT: begin
        tmr_last = RETRY_LAST;
        if (!en_i) begin
          state_d = SQ_HOLD;
        end else begin
          tmr_clr = 1'b0;
          tmr_run = 1'b1;
          if (tmr_exp) begin
            state_d = SQ_ON;
            on_d    = 1'b1;
          end
        end
      end
      SQ_HOLD: begin
        if (en_i) begin
          state_d = SQ_ON;
          on_d    = 1'b1;
        end
      end
      default: state_d = SQ_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_BOOT;
      on_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      on_q    <= on_d;
    end
  end

  assign on_req_o = on_q;
  assign wait_o   = (state_q == SQ_WAIT);
  assign hold_o   = (state_q == SQ_HOLD);

  AST_ONREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    on_req_o |=> !on_req_o) else $error("on request longer than one cycle"); // R11
  AST_WAIT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_o) |-> (on_req_o || hold_o)) else $error("retry wait ended without outcome"); // R2
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> !$past(en_i)) else $error("held off while retry permitted"); // R7
  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && !en_i) |=> !on_req_o) else $error("on request while held off"); // R8
endmodule

// File: rtl/relimit_enable_guard.sv
module relimit_enable_guard #(
  parameter int ARM_WIN   = 8,
  parameter int SCRUB_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_arm_i,
  input  logic cmd_confirm_i,
  input  logic cmd_enable_i,
  input  logic core_en_i,
  output logic en_o,
  output logic wr_o
);
  localparam int AW = $clog2(ARM_WIN + 1);
  localparam int SW = $clog2(SCRUB_CYC + 1);
  localparam logic [AW-1:0] ARM_LAST   = AW'(ARM_WIN - 1);
  localparam logic [SW-1:0] SCRUB_LAST = SW'(SCRUB_CYC - 1);

  logic intent_q, intent_d;
  logic armed_q,  armed_d;
  logic boot_q;
  logic wr_q,     wr_d;
  logic arm_exp,  scrub_exp;
  logic mismatch;
  logic changed;

  assign changed  = (intent_d != intent_q);
  assign mismatch = (core_en_i != intent_q) && !boot_q;

  relimit_span_timer #(.CW(AW)) u_arm_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (!armed_q || cmd_arm_i),
    .run_i    (armed_q),
    .last_i   (ARM_LAST),
    .expire_o (arm_exp)
  );

  relimit_span_timer #(.CW(SW)) u_scrub_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (!mismatch || changed),
    .run_i    (mismatch),
    .last_i   (SCRUB_LAST),
    .expire_o (scrub_exp)
  );

  always_comb begin
    intent_d = intent_q;
    armed_d  = armed_q;
    if (cmd_enable_i) begin
      intent_d = 1'b1;
      armed_d  = 1'b0;
    end else if (armed_q && cmd_confirm_i) begin
      intent_d = 1'b0;
      armed_d  = 1'b0;
    end else if (cmd_arm_i) begin
      armed_d  = 1'b1;
    end else if (arm_exp) begin
      armed_d  = 1'b0;
    end
  end

  always_comb begin
    wr_d = boot_q || changed || (scrub_exp && !changed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intent_q <= 1'b1;
      armed_q  <= 1'b0;
      boot_q   <= 1'b1;
      wr_q     <= 1'b0;
    end else begin
      intent_q <= intent_d;
      armed_q  <= armed_d;
      boot_q   <= 1'b0;
      wr_q     <= wr_d;
    end
  end

  assign en_o = intent_q;
  assign wr_o = wr_q;

  AST_DISABLE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_o) |-> $past(armed_q)) else $error("withdrawal without arm"); // R6
  AST_WRITE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o != $past(en_o)) |-> wr_o) else $error("permission changed without write"); // R5
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cmd_confirm_i && !cmd_enable_i) |=> (!armed_q && !en_o)) else $error("confirm not taken"); // R5
endmodule

// File: rtl/relimit_seq.sv
module relimit_seq #(
  parameter int RETRY_CYC = 40,
  parameter int TRIP_CYC  = 16,
  parameter int WDOG_CYC  = 24,
  parameter int ARM_WIN   = 8,
  parameter int SCRUB_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic core_on_i,
  input  logic core_en_i,
  input  logic cmd_arm_i,
  input  logic cmd_confirm_i,
  input  logic cmd_enable_i,
  output logic on_req_o,
  output logic en_wr_o,
  output logic retrig_en_o,
  output logic retry_wait_o,
  output logic latched_off_o
);
  generate
    if (RETRY_CYC <= TRIP_CYC) begin : g_bad_retry
      $error("retry interval must exceed trip-off time");
    end
  endgenerate

  logic srst_n;

  relimit_rst_sync u_rst_sync (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  relimit_enable_guard #(
    .ARM_WIN   (ARM_WIN),
    .SCRUB_CYC (SCRUB_CYC)
  ) u_guard (
    .clk           (clk),
    .rst_n         (srst_n),
    .cmd_arm_i     (cmd_arm_i),
    .cmd_confirm_i (cmd_confirm_i),
    .cmd_enable_i  (cmd_enable_i),
    .core_en_i     (core_en_i),
    .en_o          (retrig_en_o),
    .wr_o          (en_wr_o)
  );

  relimit_retry_fsm #(
    .RETRY_CYC (RETRY_CYC),
    .WDOG_CYC  (WDOG_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (srst_n),
    .trip_i    (trip_i),
    .core_on_i (core_on_i),
    .en_i      (retrig_en_o),
    .on_req_o  (on_req_o),
    .wait_o    (retry_wait_o),
    .hold_o    (latched_off_o)
  );

  AST_WAIT_XOR_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !(retry_wait_o && latched_off_o)) else $error("waiting and held at once"); // R8
endmodule

// File: tb/relimit_seq_bench.sv
module relimit_seq_bench;
  localparam int RETRY_CYC = 40;
  localparam int TRIP_CYC  = 16;
  localparam int WDOG_CYC  = 24;
  localparam int ARM_WIN   = 8;
  localparam int SCRUB_CYC = 12;
  localparam int NV = 5;

  // {spurious_off, expected latency}
  localparam logic [16:0] TBL [NV] = '{
    {1'b0, 16'(RETRY_CYC + 1)},
    {1'b1, 16'(WDOG_CYC + 1)},
    {1'b0, 16'(RETRY_CYC + 1)},
    {1'b0, 16'(RETRY_CYC + 1)},
    {1'b1, 16'(WDOG_CYC + 1)}
  };

  logic clk = 1'b0;
  logic rst_n, trip_i, core_on_i, core_en_i;
  logic cmd_arm_i, cmd_confirm_i, cmd_enable_i;
  logic on_req_o, en_wr_o, retrig_en_o, retry_wait_o, latched_off_o;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  relimit_seq #(
    .RETRY_CYC (RETRY_CYC), .TRIP_CYC (TRIP_CYC), .WDOG_CYC (WDOG_CYC),
    .ARM_WIN (ARM_WIN), .SCRUB_CYC (SCRUB_CYC)
  ) u_relimit_seq (
    .clk (clk), .rst_n (rst_n), .trip_i (trip_i), .core_on_i (core_on_i),
    .core_en_i (core_en_i), .cmd_arm_i (cmd_arm_i), .cmd_confirm_i (cmd_confirm_i),
    .cmd_enable_i (cmd_enable_i), .on_req_o (on_req_o), .en_wr_o (en_wr_o),
    .retrig_en_o (retrig_en_o), .retry_wait_o (retry_wait_o),
    .latched_off_o (latched_off_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_sig(input bit which, input int limit, output int n, output bit mid);
    n = 0;
    mid = 1'b0;
    do begin
      @(negedge clk);
      n++;
      trip_i = 1'b0; cmd_arm_i = 1'b0; cmd_confirm_i = 1'b0; cmd_enable_i = 1'b0;
      if (n == 2) mid = retry_wait_o;
    end while (!(which ? en_wr_o : on_req_o) && n < limit);
  endtask

  task automatic count_pulses(input bit which, input int cycles, output int n);
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (which ? en_wr_o : on_req_o) n++;
    end
  endtask

  task automatic arm_confirm(input int d);
    cmd_arm_i = 1'b1;
    tick();
    cmd_arm_i = 1'b0;
    repeat (d - 1) tick();
    cmd_confirm_i = 1'b1;
    tick();
    cmd_confirm_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    bit mid;
    rst_n = 1'b0; trip_i = 1'b0; core_on_i = 1'b1; core_en_i = 1'b1;
    cmd_arm_i = 1'b0; cmd_confirm_i = 1'b0; cmd_enable_i = 1'b0;
    repeat (3) tick();
    // R1 reset state
    chk(!on_req_o && !en_wr_o, "R1 pulses quiet in reset", on_req_o + en_wr_o, 0);
    chk(retrig_en_o == 1'b1, "R1 permission set in reset", retrig_en_o, 1);
    chk(!retry_wait_o && !latched_off_o, "R1 status clear in reset", retry_wait_o + latched_off_o, 0);
    rst_n = 1'b1;
    wait_sig(1'b0, 10, n, mid);
    chk(n == 3, "R1 on request after reset", n, 3);
    chk(en_wr_o == 1'b1, "R1 permission write after reset", en_wr_o, 1);
    tick();
    chk(!on_req_o, "R11 single-cycle on request", on_req_o, 0);

    // R4 steady ON
    count_pulses(1'b0, 60, n);
    chk(n == 0, "R4 no request while ON", n, 0);

    // R2 R3 R9 vector table
    for (int i = 0; i < NV; i++) begin
      if (TBL[i][16]) begin
        core_on_i = 1'b0;
      end else begin
        trip_i = 1'b1;
        core_on_i = 1'b0;
      end
      wait_sig(1'b0, 400, n, mid);
      if (TBL[i][16])
        chk(n == int'(TBL[i][15:0]), "R9 spurious-off restore latency", n, int'(TBL[i][15:0]));
      else begin
        chk(n == int'(TBL[i][15:0]), (i == 0) ? "R2 retry latency" : "R3 repeated retry latency",
            n, int'(TBL[i][15:0]));
        chk(mid == 1'b1, "R2 retry wait flagged", mid, 1);
      end
      core_on_i = 1'b1;
      tick();
      chk(!on_req_o, "R11 single-cycle on request", on_req_o, 0);
      repeat (3) tick();
    end

    // R6 late confirm and unarmed confirm
    arm_confirm(ARM_WIN + 1);
    chk(retrig_en_o == 1'b1 && !en_wr_o, "R6 late confirm ignored", retrig_en_o, 1);
    cmd_confirm_i = 1'b1;
    tick();
    cmd_confirm_i = 1'b0;
    chk(retrig_en_o == 1'b1 && !en_wr_o, "R6 unarmed confirm ignored", retrig_en_o, 1);

    // R5 confirm on last cycle of window
    arm_confirm(ARM_WIN);
    chk(retrig_en_o == 1'b0, "R5 withdrawal accepted", retrig_en_o, 0);
    chk(en_wr_o == 1'b1, "R5 withdrawal written", en_wr_o, 1);
    core_en_i = 1'b0;

    // R7 trip while withdrawn
    trip_i = 1'b1;
    core_on_i = 1'b0;
    tick();
    trip_i = 1'b0;
    chk(latched_off_o == 1'b1, "R7 latched off after trip", latched_off_o, 1);
    count_pulses(1'b0, RETRY_CYC + 10, n);
    chk(n == 0, "R7 no retry while withdrawn", n, 0);
    cmd_enable_i = 1'b1;
    tick();
    cmd_enable_i = 1'b0;
    chk(retrig_en_o == 1'b1 && en_wr_o == 1'b1, "R7 enable written", retrig_en_o + en_wr_o, 2);
    tick();
    chk(on_req_o == 1'b1, "R7 on request after enable", on_req_o, 1);
    core_on_i = 1'b1;
    core_en_i = 1'b1;
    repeat (3) tick();

    // R8 withdrawal during retry wait
    trip_i = 1'b1;
    core_on_i = 1'b0;
    tick();
    trip_i = 1'b0;
    repeat (3) tick();
    arm_confirm(2);
    chk(retrig_en_o == 1'b0, "R8 withdrawal during wait", retrig_en_o, 0);
    core_en_i = 1'b0;
    count_pulses(1'b0, RETRY_CYC + 5, n);
    chk(n == 0, "R8 pending retry cancelled", n, 0);
    chk(latched_off_o == 1'b1, "R8 held off", latched_off_o, 1);
    cmd_enable_i = 1'b1;
    tick();
    cmd_enable_i = 1'b0;
    tick();
    chk(on_req_o == 1'b1, "R7 on request after re-enable", on_req_o, 1);
    core_on_i = 1'b1;
    core_en_i = 1'b1;
    repeat (3) tick();

    // R10 scrub of corrupted permission latch
    core_en_i = 1'b0;
    wait_sig(1'b1, 100, n, mid);
    chk(n == SCRUB_CYC, "R10 scrub write latency", n, SCRUB_CYC);
    chk(retrig_en_o == 1'b1, "R10 permission kept", retrig_en_o, 1);
    core_en_i = 1'b1;
    repeat (3) tick();
    core_en_i = 1'b0;
    count_pulses(1'b1, SCRUB_CYC - 1, n);
    core_en_i = 1'b1;
    begin
      int m;
      count_pulses(1'b1, SCRUB_CYC + 4, m);
      chk(n + m == 0, "R10 short mismatch no write", n + m, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule